// File: doc/BRIEF.md
# SPI Status and Error Flag Unit

This block owns the combined status/configuration register of a byte-wide SPI peripheral. It watches strobes from the neighbouring shift engine: a byte has finished shifting in, and the pending transmit byte has moved into the shifter. It keeps four condition flags from these strobes and from the pin and mode inputs: receive buffer full, transmit buffer empty, receive overrun and slave-select mode fault. It also holds four software-writable bits: the error interrupt enable, the mode-fault detection enable and a two-bit baud selection that it passes on to the clock divider.

No flag can be cleared by a direct write. Software clears a flag with a two-step access. First it reads the status register while the flag is set, which arms the flag. Then it performs a particular follow-up access. For receive-full and overrun this is a read of the data register. For mode fault it is a write to the control register. When an overrun occurs, the byte already in the receive buffer is kept and the new byte is dropped. To do this the block withholds the receive-buffer load enable it gives to the data path.

Top module: `spi_stat_unit`

## Requirements
- R1: Once the internal reset has been released, the register reads 8'h08: transmit-empty is 1 and every other bit is 0. Both interrupt requests are low.
- R2: The read value bits, from bit 7 down to bit 0, are: receive-full, error interrupt enable, overrun, mode fault, transmit-empty, mode-fault detect enable, baud select [1:0].
- R3: A `byte_done` strobe while receive-full is 0 pulses `rx_latch_en` in that same cycle, and receive-full reads 1 from the next cycle on.
- R4: Receive-full clears only on a data-register read that follows a status read taken while receive-full was 1. A data read with no such status read before it leaves the flag set. Each data read uses up the arming.
- R5: A `byte_done` while receive-full is 1, in a cycle with no clearing data read, sets overrun. In that cycle `rx_latch_en` stays low, so the stored byte is kept.
- R6: Overrun clears on a data-register read that follows a status read taken while overrun was 1.
- R7: When detection is enabled, a slave (`is_master`=0) sets mode fault when `ss_level` is high while `xfer_active` is 1. With `xfer_active` at 0, a high `ss_level` has no effect.
- R8: When detection is enabled, a master sets mode fault whenever `ss_level` is low.
- R9: Mode fault clears on a control-register write that follows a status read taken while mode fault was 1. A data read does not clear it.
- R10: Transmit-empty goes to 0 on a data-register write and to 1 on `tx_load`. If both happen in the same cycle, the write wins and the flag reads 0.
- R11: A status write updates only bits 6, 2, 1 and 0. Writes to bits 7, 5, 4 and 3 are ignored. `baud_sel` always equals bits 1:0.
- R12: `rx_irq` equals receive-full AND `rx_ie`. `err_irq` equals error-enable AND (overrun OR mode fault).
- R13: If a clearing data read and a `byte_done` fall in the same cycle, the new byte is latched, receive-full stays 1 and overrun does not set. A flag's set condition wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done | input | 1 | Shift engine finished receiving a byte |
| tx_load | input | 1 | Transmit byte moved into the shifter |
| ss_level | input | 1 | Slave-select pin level (1 = high) |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| xfer_active | input | 1 | A transfer is in progress |
| rx_ie | input | 1 | Receive interrupt enable from the control register |
| rd_stat | input | 1 | Bus read of the status register |
| wr_stat | input | 1 | Bus write of the status register |
| rd_data | input | 1 | Bus read of the data register |
| wr_data | input | 1 | Bus write of the data register |
| wr_ctrl | input | 1 | Bus write of the control register |
| wdata | input | 8 | Bus write data |
| stat_rdata | output | 8 | Status register read value |
| baud_sel | output | 2 | Baud select bits for the divider |
| rx_latch_en | output | 1 | Load enable for the receive data register |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench targets the cases where a byte arrives in the same cycle as the clearing data read. A design that checked receive-full only before the clear would raise a false overrun there and lose a valid byte. Directed sequences try a data read with no status read before it, and a data read aimed at a mode fault. A design that cleared on any access would drop flags software never saw. The bench also drives a second byte while the buffer is full, to catch a design that overwrites the old byte, and a data write in the same cycle as a transmit load, to catch a design that reports an empty buffer while a byte is pending.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int REG_W    = 8;
  localparam int BAUD_W   = 2;
  localparam int RST_SYNC = 2;

  // bit positions of the writable fields
  localparam int POS_EIE = 6;
  localparam int POS_MFE = 2;

  typedef struct packed {
    logic              rx_full;
    logic              err_ie;
    logic              ovr;
    logic              mfault;
    logic              tx_empty;
    logic              mf_en;
    logic [BAUD_W-1:0] baud;
  } stat_t;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_done,
  input  logic rd_stat,
  input  logic rd_data,
  output logic latch_en,
  output logic rx_full,
  output logic ovr
);
  logic full_q, full_d, ovr_q, ovr_d;
  logic arm_full_q, arm_full_d, arm_ovr_q, arm_ovr_d;
  logic clr_full, clr_ovr, lost;

  always_comb begin
    clr_full = rd_data & arm_full_q;
    clr_ovr  = rd_data & arm_ovr_q;
    latch_en = byte_done & (~full_q | clr_full);
    lost     = byte_done & full_q & ~clr_full;

    full_d = full_q;
    if (clr_full) full_d = 1'b0;
    if (latch_en) full_d = 1'b1;

    ovr_d = ovr_q;
    if (clr_ovr) ovr_d = 1'b0;
    if (lost)    ovr_d = 1'b1;

    arm_full_d = arm_full_q;
    arm_ovr_d  = arm_ovr_q;
    if (rd_data) begin
      arm_full_d = 1'b0;
      arm_ovr_d  = 1'b0;
    end
    if (rd_stat) begin
      arm_full_d = full_q;
      arm_ovr_d  = ovr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      arm_full_q <= 1'b0;
      arm_ovr_q  <= 1'b0;
    end else begin
      full_q     <= full_d;
      ovr_q      <= ovr_d;
      arm_full_q <= arm_full_d;
      arm_ovr_q  <= arm_ovr_d;
    end
  end

  assign rx_full = full_q;
  assign ovr     = ovr_q;
endmodule

// File: rtl/spi_mode_fault.sv
module spi_mode_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_en,
  input  logic is_master,
  input  logic ss_level,
  input  logic xfer_active,
  input  logic rd_stat,
  input  logic wr_ctrl,
  output logic mfault
);
  logic mf_q, mf_d, arm_q, arm_d, detect, clr;

  always_comb begin
    detect = mf_en & (is_master ? ~ss_level : (ss_level & xfer_active));
    clr    = wr_ctrl & arm_q;

    mf_d = mf_q;
    if (clr)    mf_d = 1'b0;
    if (detect) mf_d = 1'b1;

    arm_d = arm_q;
    if (wr_ctrl) arm_d = 1'b0;
    if (rd_stat) arm_d = mf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      mf_q  <= mf_d;
      arm_q <= arm_d;
    end
  end

  assign mfault = mf_q;
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wr_data,
  input  logic              tx_load,
  output logic              err_ie,
  output logic              mf_en,
  output logic [BAUD_W-1:0] baud,
  output logic              tx_empty
);
  logic tx_q, tx_d, eie_q, mfe_q;
  logic [BAUD_W-1:0] baud_q;

  always_comb begin
    tx_d = tx_q;
    if (tx_load) tx_d = 1'b1;
    if (wr_data) tx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b1;
    else        tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eie_q  <= 1'b0;
      mfe_q  <= 1'b0;
      baud_q <= '0;
    end else if (wr_stat) begin
      eie_q  <= wdata[POS_EIE];
      mfe_q  <= wdata[POS_MFE];
      baud_q <= wdata[BAUD_W-1:0];
    end
  end

  assign tx_empty = tx_q;
  assign err_ie   = eie_q;
  assign mf_en    = mfe_q;
  assign baud     = baud_q;
endmodule

// File: rtl/spi_stat_unit.sv
module spi_stat_unit
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic              tx_load,
  input  logic              ss_level,
  input  logic              is_master,
  input  logic              xfer_active,
  input  logic              rx_ie,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic              rd_data,
  input  logic              wr_data,
  input  logic              wr_ctrl,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  stat_rdata,
  output logic [BAUD_W-1:0] baud_sel,
  output logic              rx_latch_en,
  output logic              rx_irq,
  output logic              err_irq
);
  logic rst_core_n;
  stat_t st;

  spi_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  spi_rx_flags u_rx (
    .clk(clk), .rst_n(rst_core_n), .byte_done(byte_done),
    .rd_stat(rd_stat), .rd_data(rd_data), .latch_en(rx_latch_en),
    .rx_full(st.rx_full), .ovr(st.ovr)
  );

  spi_mode_fault u_mf (
    .clk(clk), .rst_n(rst_core_n), .mf_en(st.mf_en),
    .is_master(is_master), .ss_level(ss_level),
    .xfer_active(xfer_active), .rd_stat(rd_stat),
    .wr_ctrl(wr_ctrl), .mfault(st.mfault)
  );

  spi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr_stat(wr_stat), .wdata(wdata),
    .wr_data(wr_data), .tx_load(tx_load), .err_ie(st.err_ie),
    .mf_en(st.mf_en), .baud(st.baud), .tx_empty(st.tx_empty)
  );

  assign stat_rdata = st;
  assign baud_sel   = st.baud;
  assign rx_irq     = st.rx_full & rx_ie;
  assign err_irq    = st.err_ie & (st.ovr | st.mfault);
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_done,
  input logic       tx_load,
  input logic       ss_level,
  input logic       is_master,
  input logic       xfer_active,
  input logic       rd_stat,
  input logic       rd_data,
  input logic       wr_data,
  input logic [7:0] stat_rdata,
  input logic       rx_latch_en,
  input logic       rx_irq,
  input logic       err_irq
);
  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> stat_rdata[7]);

  assert_keep_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && byte_done && !rd_data) |-> !rx_latch_en);

  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && byte_done && !rd_data) |=> stat_rdata[5]);

  assert_full_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && rd_stat && !rd_data) ##1 (rd_data && !rd_stat && !byte_done)
      |=> !stat_rdata[7]);

  assert_tx_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !stat_rdata[3]);

  assert_tx_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_data) |=> stat_rdata[3]);

  assert_mf_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[2] && is_master && !ss_level) |=> stat_rdata[4]);

  assert_mf_slave_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[2] && !is_master && ss_level && xfer_active) |=> stat_rdata[4]);

  assert_rx_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> stat_rdata[7]);

  assert_err_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (stat_rdata[6] && (stat_rdata[5] || stat_rdata[4])));
endmodule

bind spi_stat_unit spi_stat_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .byte_done(byte_done), .tx_load(tx_load),
  .ss_level(ss_level), .is_master(is_master), .xfer_active(xfer_active),
  .rd_stat(rd_stat), .rd_data(rd_data), .wr_data(wr_data),
  .stat_rdata(stat_rdata), .rx_latch_en(rx_latch_en),
  .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/sim_spi_stat_unit.sv
module sim_spi_stat_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, byte_done, tx_load, ss_level, is_master, xfer_active, rx_ie;
  logic rd_stat, wr_stat, rd_data, wr_data, wr_ctrl;
  logic [7:0] wdata, stat_rdata;
  logic [1:0] baud_sel;
  logic rx_latch_en, rx_irq, err_irq;

  spi_stat_unit u0 (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench reference state
  bit m_full, m_ovr, m_mf, m_tx, m_eie, m_mfe;
  bit [1:0] m_baud;
  bit a_full, a_ovr, a_mf;

  typedef struct {
    bit bd, tl, rs, rdd, wc, wd, ws, ss, ms, xa, rie;
    bit [7:0] wv;
  } stim_t;

  function automatic stim_t idle();
    stim_t s = '{default: 0};
    s.ss = 1;
    return s;
  endfunction

  function automatic bit [7:0] m_stat();
    return {m_full, m_eie, m_ovr, m_mf, m_tx, m_mfe, m_baud};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic go(stim_t s);
    bit lat, lost, cf, co, cm, det;
    byte_done = s.bd; tx_load = s.tl; rd_stat = s.rs; rd_data = s.rdd;
    wr_ctrl = s.wc; wr_data = s.wd; wr_stat = s.ws; wdata = s.wv;
    ss_level = s.ss; is_master = s.ms; xfer_active = s.xa; rx_ie = s.rie;
    #1;
    cf  = s.rdd & a_full;
    co  = s.rdd & a_ovr;
    cm  = s.wc & a_mf;
    lat = s.bd & (!m_full | cf);
    lost = s.bd & m_full & !cf;
    det = m_mfe & (s.ms ? !s.ss : (s.ss & s.xa));
    chk("R2 status", stat_rdata, m_stat());
    chk("R11 baud", baud_sel, m_baud);
    chk("R3 latch", rx_latch_en, lat);
    chk("R12 rx_irq", rx_irq, m_full & s.rie);
    chk("R12 err_irq", err_irq, m_eie & (m_ovr | m_mf));
    @(posedge clk);
    if (s.rdd) begin a_full = 0; a_ovr = 0; end
    if (s.rs)  begin a_full = m_full; a_ovr = m_ovr; end
    if (s.wc) a_mf = 0;
    if (s.rs) a_mf = m_mf;
    m_full = lat ? 1 : (cf ? 0 : m_full);
    m_ovr  = lost ? 1 : (co ? 0 : m_ovr);
    m_mf   = det ? 1 : (cm ? 0 : m_mf);
    m_tx   = s.wd ? 0 : (s.tl ? 1 : m_tx);
    if (s.ws) begin m_eie = s.wv[6]; m_mfe = s.wv[2]; m_baud = s.wv[1:0]; end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    stim_t s;
    void'($urandom(32'h5EED_0042));
    rst_n = 0;
    byte_done = 0; tx_load = 0; rd_stat = 0; rd_data = 0; wr_ctrl = 0;
    wr_data = 0; wr_stat = 0; wdata = 0; ss_level = 1; is_master = 0;
    xfer_active = 0; rx_ie = 0;
    {m_full, m_ovr, m_mf, m_eie, m_mfe, m_baud, a_full, a_ovr, a_mf} = '0;
    m_tx = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 reset", stat_rdata, 8'h08);
    chk("R1 irqs", {rx_irq, err_irq}, 0);

    // R11 only writable bits take
    s = idle(); s.ws = 1; s.wv = 8'hFF; go(s);
    chk("R11 write ff", stat_rdata, 8'h4F);
    chk("R11 baud_sel", baud_sel, 3);
    s.wv = 8'h00; go(s);
    chk("R11 write 00", stat_rdata, 8'h08);

    // R3 receive then R4 unarmed read keeps flag
    s = idle(); s.bd = 1; go(s);
    chk("R3 full set", stat_rdata[7], 1);
    s = idle(); s.rdd = 1; go(s);
    chk("R4 unarmed read", stat_rdata[7], 1);
    s = idle(); s.rs = 1; go(s);
    s = idle(); go(s);
    s = idle(); s.rdd = 1; go(s);
    chk("R4 armed clear", stat_rdata[7], 0);

    // R5 overrun keeps old byte, R6 clear
    s = idle(); s.bd = 1; go(s);
    go(s);
    chk("R5 overrun", stat_rdata, 8'hA8);
    s = idle(); s.rs = 1; go(s);
    s = idle(); s.rdd = 1; go(s);
    chk("R6 ovr clear", stat_rdata, 8'h08);

    // R13 clearing read coincides with new byte
    s = idle(); s.bd = 1; go(s);
    s = idle(); s.rs = 1; go(s);
    s = idle(); s.rdd = 1; s.bd = 1; go(s);
    chk("R13 same cycle", stat_rdata, 8'h88);
    s = idle(); s.rs = 1; go(s);
    s = idle(); s.rdd = 1; go(s);

    // R7 slave mode fault
    s = idle(); s.ws = 1; s.wv = 8'h44; go(s);
    s = idle(); go(s);
    chk("R7 idle high no fault", stat_rdata[4], 0);
    s = idle(); s.xa = 1; go(s);
    chk("R7 slave fault", stat_rdata[4], 1);
    chk("R12 err_irq", err_irq, 1);
    // R9 data read does not clear, control write does
    s = idle(); s.rs = 1; go(s);
    s = idle(); s.rdd = 1; go(s);
    chk("R9 data read", stat_rdata[4], 1);
    s = idle(); s.rs = 1; go(s);
    s = idle(); s.wc = 1; go(s);
    chk("R9 ctrl clear", stat_rdata[4], 0);

    // R8 master fault
    s = idle(); s.ms = 1; s.ss = 0; go(s);
    chk("R8 master fault", stat_rdata[4], 1);
    s = idle(); s.ms = 1; s.rs = 1; go(s);
    s = idle(); s.ms = 1; s.wc = 1; go(s);
    chk("R9 master clear", stat_rdata[4], 0);

    // R10 transmit-empty
    s = idle(); s.wd = 1; go(s);
    chk("R10 write clears", stat_rdata[3], 0);
    s = idle(); s.tl = 1; go(s);
    chk("R10 load sets", stat_rdata[3], 1);
    s = idle(); s.tl = 1; s.wd = 1; go(s);
    chk("R10 write wins", stat_rdata[3], 0);

    // R12 receive interrupt
    s = idle(); s.bd = 1; go(s);
    s = idle(); s.rie = 1; go(s);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      s = idle();
      s.bd  = ($urandom % 4) == 0;
      s.tl  = ($urandom % 5) == 0;
      s.rs  = ($urandom % 3) == 0;
      s.rdd = ($urandom % 4) == 0;
      s.wc  = ($urandom % 6) == 0;
      s.wd  = ($urandom % 5) == 0;
      s.ws  = ($urandom % 10) == 0;
      s.wv  = 8'($urandom);
      s.ss  = ($urandom % 8) != 0;
      s.ms  = ($urandom % 3) == 0;
      s.xa  = ($urandom % 4) == 0;
      s.rie = $urandom % 2;
      go(s);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule